// File: doc/BRIEF.md
# Switch Address Table Command Engine

This block keeps a small table of learned MAC addresses for an Ethernet switch and changes it only through commands issued by a host over a simple register port. Each table entry carries a database number, a 48-bit MAC address, a 4-bit state (zero means empty), a trunk flag and a port vector. The host fills in the address registers, the data register and the database number, then writes the command register with its top bit set. The engine walks the whole table one entry per cycle, applies the command and drops the busy flag. The host polls that flag before it reads results or issues the next command.

Four kinds of work are supported. A load inserts, replaces or purges one entry. A get-next hands back, in ascending address order, the entries of one database. A flush deletes entries. A move rewrites the port vectors of entries. Flush and move share four opcodes, which cover either every database or one, and either every entry or only the non-static ones. The state in the data register picks between deleting and moving.

Top module: `addr_table_engine`

## Requirements
- R1: Writing register 2 with bit 15 set while idle starts a command. `busy` (and bit 15 of register 2 on read) is 1 for exactly DEPTH+1 cycles after that write edge and then returns to 0.
- R2: Register writes that arrive while `busy` is 1 are ignored. This includes a write that would start a new command.
- R3: Register map: 0 is the wide database select, 1 is control, 2 is command, 3 is data, and 4, 5 and 6 hold the MAC. Register 4 holds address bytes 0 and 1, register 5 bytes 2 and 3, register 6 bytes 4 and 5, and the lower-numbered byte of each pair sits in bits 15:8. In the data register the state is in bits 3:0, the port vector starts at bit 4 (NPORT bits), the trunk flag is bit 15, and bits 12 to 14 read back as 0 after a get-next. Every register resets to 0.
- R4: For DB_W up to 8, the database number is {control[15:12], command[9:8], command[3:0]}, cut down to DB_W bits. For DB_W above 8 it is register 0 bits DB_W-1:0. Entries in other databases are invisible to load, to get-next and to the single-database flush/move opcodes.
- R5: A load (command bits 14:12 = 3) with a nonzero state writes the entry for that MAC and database, or replaces it if it already exists.
- R6: A load with state 0 purges the entry for that MAC and database.
- R7: A get-next (opcode 4) returns, in the MAC and data registers, the valid entry of the database whose MAC is the smallest one above the MAC registers. The all-ones MAC means "start from the lowest".
- R8: When no further entry exists, a get-next leaves all-ones in the MAC registers and 0 in the data register.
- R9: Flush/move opcodes: 1 covers all entries in all databases, 2 non-static entries in all databases, 5 all entries in one database, 6 non-static entries in one database. With data state 0, every selected entry is deleted.
- R10: An entry is static when its state is 0xE or 0xF. Opcodes 2 and 6 leave static entries unchanged.
- R11: With data state 0xF, the opcode performs a move. The port vector's low NPORT/2 bits give the from-port and the next NPORT/2 bits give the to-port. Each selected entry that has the from-port bit set loses that bit and gains the to-port bit.
- R12: A move whose to-port field is all ones removes each selected entry that has the from-port bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| busy | output | 1 | Command in progress |

## Verification
The bench builds the block with DEPTH=8, DB_W=8 and NPORT=8. With DB_W=8 the database number is spread over two command fields and the control field, so the test uses database 0x35 next to database 0x05 and shows that the bits coming from the control register separate two entries with the same MAC. NPORT=8 gives 4-bit from-port and to-port fields, so a to-port of 0xF reaches the removal case, and moves between ports 0, 2 and 6 exercise the bit replacement on both static and non-static entries.

// File: rtl/addr_table_engine.sv
module addr_table_engine #(
  parameter int DEPTH = 8,
  parameter int DB_W  = 8,
  parameter int NPORT = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [15:0] wr_data,
  input  logic [2:0]  rd_addr,
  output logic [15:0] rd_data,
  output logic        busy
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int HW = NPORT / 2;
  localparam logic [2:0] A_DBSEL = 3'd0, A_CTRL = 3'd1, A_OP = 3'd2, A_DATA = 3'd3;
  localparam logic [2:0] A_MAC0 = 3'd4, A_MAC1 = 3'd5, A_MAC2 = 3'd6;
  localparam logic [2:0] OP_LOAD = 3'd3, OP_NEXT = 3'd4;
  localparam logic [2:0] OP_FM_ALL = 3'd1, OP_FM_NS = 3'd2, OP_FM_ALL_DB = 3'd5, OP_FM_NS_DB = 3'd6;

  logic [15:0] dbsel_r, ctrl_r, op_r, data_r, mac_r0, mac_r1, mac_r2;
  logic busy_r, fin_r;
  logic [IW-1:0] idx;
  logic hit_v, free_v, best_v;
  logic [IW-1:0] hit_i, free_i, best_i;
  logic [47:0] best_mac;

  logic [47:0]      t_mac [DEPTH];
  logic [DB_W-1:0]  t_db  [DEPTH];
  logic [3:0]       t_st  [DEPTH];
  logic             t_trk [DEPTH];
  logic [NPORT-1:0] t_pv  [DEPTH];

  wire [11:0] db_raw = (DB_W > 8) ? dbsel_r[11:0]
                                  : {4'b0, ctrl_r[15:12], op_r[9:8], op_r[3:0]};
  wire [DB_W-1:0]  cur_db = db_raw[DB_W-1:0];
  wire [47:0]      key    = {mac_r0, mac_r1, mac_r2};
  wire [2:0]       opc    = op_r[14:12];
  wire [3:0]       d_st   = data_r[3:0];
  wire [NPORT-1:0] d_pv   = data_r[4 +: NPORT];
  wire [HW-1:0]    mv_from = d_pv[HW-1:0];
  wire [HW-1:0]    mv_to   = d_pv[2*HW-1:HW];
  wire [NPORT-1:0] from_bit = {{(NPORT-1){1'b0}}, 1'b1} << mv_from;
  wire [NPORT-1:0] to_bit   = {{(NPORT-1){1'b0}}, 1'b1} << mv_to;

  wire [3:0]       e_st  = t_st[idx];
  wire [NPORT-1:0] e_pv  = t_pv[idx];
  wire             e_val = (e_st != 4'd0);
  wire             e_dbm = (t_db[idx] == cur_db);
  wire             e_stat = (e_st >= 4'hE);

  wire start  = wr_en && !busy_r && (wr_addr == A_OP) && wr_data[15];
  wire scan   = busy_r && !fin_r;
  wire is_fm  = (opc == OP_FM_ALL) || (opc == OP_FM_NS) || (opc == OP_FM_ALL_DB) || (opc == OP_FM_NS_DB);
  wire fm_ns  = (opc == OP_FM_NS) || (opc == OP_FM_NS_DB);
  wire fm_sel = e_val && (!opc[2] || e_dbm) && (!fm_ns || !e_stat);
  wire from_hit = |(e_pv & from_bit);
  wire mac_eq   = e_val && e_dbm && (t_mac[idx] == key);
  wire next_ok  = e_val && e_dbm && ((&key) || (t_mac[idx] > key)) &&
                  (!best_v || (t_mac[idx] < best_mac));

  logic [15:0] data_nx;
  always_comb begin
    data_nx = '0;
    data_nx[3:0] = t_st[best_i];
    data_nx[4 +: NPORT] = t_pv[best_i];
    data_nx[15] = t_trk[best_i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dbsel_r <= '0; ctrl_r <= '0; op_r <= '0; data_r <= '0;
      mac_r0 <= '0; mac_r1 <= '0; mac_r2 <= '0;
      busy_r <= 1'b0; fin_r <= 1'b0; idx <= '0;
      hit_v <= 1'b0; free_v <= 1'b0; best_v <= 1'b0;
      hit_i <= '0; free_i <= '0; best_i <= '0; best_mac <= '0;
    end else begin
      if (wr_en && !busy_r) begin
        case (wr_addr)
          A_DBSEL: dbsel_r <= wr_data;
          A_CTRL:  ctrl_r  <= wr_data;
          A_OP:    op_r    <= {1'b0, wr_data[14:0]};
          A_DATA:  data_r  <= wr_data;
          A_MAC0:  mac_r0  <= wr_data;
          A_MAC1:  mac_r1  <= wr_data;
          A_MAC2:  mac_r2  <= wr_data;
          default: ;
        endcase
      end
      if (start) begin
        busy_r <= 1'b1; fin_r <= 1'b0; idx <= '0;
        hit_v <= 1'b0; free_v <= 1'b0; best_v <= 1'b0;
      end else if (scan) begin
        if (opc == OP_LOAD) begin
          if (mac_eq) begin hit_v <= 1'b1; hit_i <= idx; end
          if (!e_val && !free_v) begin free_v <= 1'b1; free_i <= idx; end
        end
        if (opc == OP_NEXT && next_ok) begin
          best_v <= 1'b1; best_i <= idx; best_mac <= t_mac[idx];
        end
        idx <= idx + 1'b1;
        if (idx == IW'(DEPTH - 1)) fin_r <= 1'b1;
      end else if (busy_r) begin
        busy_r <= 1'b0;
        fin_r  <= 1'b0;
        if (opc == OP_NEXT) begin
          if (best_v) begin
            {mac_r0, mac_r1, mac_r2} <= best_mac;
            data_r <= data_nx;
          end else begin
            {mac_r0, mac_r1, mac_r2} <= '1;
            data_r <= '0;
          end
        end
      end
    end
  end

  wire [IW-1:0] ld_i = hit_v ? hit_i : free_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        t_mac[i] <= '0; t_db[i] <= '0; t_st[i] <= '0; t_trk[i] <= 1'b0; t_pv[i] <= '0;
      end
    end else if (scan && is_fm && fm_sel) begin
      if (d_st == 4'h0) t_st[idx] <= 4'h0;
      else if (d_st == 4'hF && from_hit) begin
        if (&mv_to) t_st[idx] <= 4'h0;
        else t_pv[idx] <= (e_pv & ~from_bit) | to_bit;
      end
    end else if (busy_r && fin_r && opc == OP_LOAD) begin
      if (d_st != 4'h0) begin
        if (hit_v || free_v) begin
          t_mac[ld_i] <= key; t_db[ld_i] <= cur_db; t_st[ld_i] <= d_st;
          t_trk[ld_i] <= data_r[15]; t_pv[ld_i] <= d_pv;
        end
      end else if (hit_v) t_st[hit_i] <= 4'h0;
    end
  end

  always_comb begin
    case (rd_addr)
      A_DBSEL: rd_data = dbsel_r;
      A_CTRL:  rd_data = ctrl_r;
      A_OP:    rd_data = {busy_r, op_r[14:0]};
      A_DATA:  rd_data = data_r;
      A_MAC0:  rd_data = mac_r0;
      A_MAC1:  rd_data = mac_r1;
      A_MAC2:  rd_data = mac_r2;
      default: rd_data = '0;
    endcase
  end

  assign busy = busy_r;

  p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  p_busy_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_r) |-> $past(fin_r));
  p_regs_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    scan |=> $stable(mac_r0) && $stable(mac_r1) && $stable(mac_r2) && $stable(data_r) && $stable(op_r));
  p_static_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    scan && fm_ns && e_val && e_stat |=> t_st[$past(idx)] == $past(e_st));
  p_end_marker_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_r && fin_r && opc == OP_NEXT && !best_v |=> (&{mac_r0, mac_r1, mac_r2}) && data_r == 16'h0);
endmodule

// File: tb/test_addr_table_engine.sv
module test_addr_table_engine;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic busy;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  addr_table_engine #(.DEPTH(DEPTH), .DB_W(8), .NPORT(8)) i_addr_table_engine (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy));

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [47:0] m_mac [DEPTH];
  int          m_db  [DEPTH];
  logic [3:0]  m_st  [DEPTH];
  bit          m_trk [DEPTH];
  logic [7:0]  m_pv  [DEPTH];
  logic [15:0] m_reg [7];
  int m_cnt = 0;

  task automatic run_cmd();
    int op = m_reg[2][14:12];
    int db = {m_reg[1][15:12], m_reg[2][9:8], m_reg[2][3:0]};
    logic [47:0] k = {m_reg[4], m_reg[5], m_reg[6]};
    logic [3:0] st = m_reg[3][3:0];
    logic [7:0] pv = m_reg[3][11:4];
    if (op == 3) begin
      int hit = -1, fr = -1;
      for (int i = 0; i < DEPTH; i++) begin
        if (m_st[i] != 0 && m_db[i] == db && m_mac[i] == k) hit = i;
        if (m_st[i] == 0 && fr < 0) fr = i;
      end
      if (st != 0) begin
        int w = (hit >= 0) ? hit : fr;
        if (w >= 0) begin
          m_mac[w] = k; m_db[w] = db; m_st[w] = st; m_trk[w] = m_reg[3][15]; m_pv[w] = pv;
        end
      end else if (hit >= 0) m_st[hit] = 0;
    end else if (op == 4) begin
      int b = -1;
      for (int i = 0; i < DEPTH; i++)
        if (m_st[i] != 0 && m_db[i] == db && (k == '1 || m_mac[i] > k) && (b < 0 || m_mac[i] < m_mac[b])) b = i;
      if (b >= 0) begin
        {m_reg[4], m_reg[5], m_reg[6]} = m_mac[b];
        m_reg[3] = {m_trk[b], 3'b000, m_pv[b], m_st[b]};
      end else begin
        {m_reg[4], m_reg[5], m_reg[6]} = '1;
        m_reg[3] = 16'h0;
      end
    end else if (op == 1 || op == 2 || op == 5 || op == 6) begin
      int f = pv[3:0], t = pv[7:4];
      for (int i = 0; i < DEPTH; i++) begin
        if (m_st[i] == 0) continue;
        if ((op == 5 || op == 6) && m_db[i] != db) continue;
        if ((op == 2 || op == 6) && m_st[i] >= 4'hE) continue;
        if (st == 0) m_st[i] = 0;
        else if (st == 4'hF && f < 8 && m_pv[i][f]) begin
          if (t == 15) m_st[i] = 0;
          else begin
            m_pv[i][f] = 1'b0;
            if (t < 8) m_pv[i][t] = 1'b1;
          end
        end
      end
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0;
      for (int i = 0; i < 7; i++) m_reg[i] = 16'h0;
      for (int i = 0; i < DEPTH; i++) begin
        m_st[i] = 0; m_mac[i] = 0; m_db[i] = 0; m_trk[i] = 0; m_pv[i] = 0;
      end
    end else if (m_cnt > 0) m_cnt--;
    else if (wr_en && wr_addr < 7) begin
      if (wr_addr == 2) begin
        m_reg[2] = wr_data & 16'h7fff;
        if (wr_data[15]) begin run_cmd(); m_cnt = DEPTH + 1; end
      end else m_reg[wr_addr] = wr_data;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    n_cmp++;
    if (busy !== (m_cnt > 0)) begin
      n_bad++;
      $display("FAIL R1 busy actual %0b expected %0b at %0t", busy, m_cnt > 0, $time);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    while (m_cnt > 0) @(negedge clk);
  endtask

  task automatic rd_chk(input logic [2:0] a, input string tag);
    logic [15:0] exp;
    @(negedge clk); rd_addr = a; #1;
    exp = (a == 2) ? {m_cnt > 0, m_reg[2][14:0]} : m_reg[a];
    n_cmp++;
    if (rd_data !== exp) begin
      n_bad++;
      $display("FAIL %s reg %0d actual %h expected %h", tag, a, rd_data, exp);
    end
  endtask

  task automatic cmd(input logic [2:0] op, input logic [7:0] db);
    wr(3'd1, {db[7:4], 12'h0});
    wr(3'd2, {1'b1, op, 2'b00, db[5:4], 4'h0, db[3:0]});
    wait_idle();
  endtask

  task automatic set_mac(input logic [47:0] m);
    wr(3'd4, m[47:32]); wr(3'd5, m[31:16]); wr(3'd6, m[15:0]);
  endtask

  task automatic load(input logic [47:0] m, input logic [7:0] db, input logic [3:0] st,
                      input bit trk, input logic [7:0] pv);
    set_mac(m);
    wr(3'd3, {trk, 3'b000, pv, st});
    cmd(3'd3, db);
  endtask

  task automatic dump(input logic [7:0] db, input string tag);
    set_mac('1);
    for (int n = 0; n <= DEPTH; n++) begin
      cmd(3'd4, db);
      rd_chk(3'd4, tag); rd_chk(3'd5, tag); rd_chk(3'd6, tag); rd_chk(3'd3, tag);
      if (m_reg[3] == 16'h0) break;
    end
  endtask

  task automatic fm(input logic [2:0] op, input logic [7:0] db, input logic [3:0] st,
                    input logic [7:0] pv);
    wr(3'd3, {4'h0, pv, st});
    cmd(op, db);
  endtask

  localparam logic [47:0] MAC_A = 48'h0011_2233_4455;
  localparam logic [47:0] MAC_B = 48'h0011_2233_0001;
  localparam logic [47:0] MAC_D = 48'h0000_0000_0010;
  localparam logic [47:0] MAC_E = 48'h0000_0000_0020;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 7; a++) rd_chk(3'(a), "R3 reset");
    load(MAC_A, 8'h05, 4'h7, 1'b0, 8'h04);
    load(MAC_B, 8'h05, 4'h7, 1'b0, 8'h06);
    load(MAC_A, 8'h35, 4'hE, 1'b1, 8'h40);
    dump(8'h05, "R7 R8 R3 ascending walk");
    dump(8'h35, "R4 split database");
    dump(8'h15, "R4 empty database");
    load(MAC_A, 8'h05, 4'h7, 1'b0, 8'h81);
    dump(8'h05, "R5 replace");
    load(MAC_B, 8'h05, 4'h0, 1'b0, 8'h00);
    dump(8'h05, "R6 purge");
    wr(3'd2, {1'b1, 3'd3, 12'h005});
    wr(3'd4, 16'h1234);
    wr(3'd3, 16'h00F1);
    wr(3'd2, {1'b1, 3'd1, 12'h000});
    wait_idle();
    rd_chk(3'd4, "R2 write while busy");
    rd_chk(3'd3, "R2 write while busy");
    rd_chk(3'd2, "R2 write while busy");
    dump(8'h05, "R2 table untouched");
    load(MAC_D, 8'h05, 4'hE, 1'b0, 8'h04);
    load(MAC_E, 8'h05, 4'h3, 1'b0, 8'h04);
    fm(3'd2, 8'h00, 4'hF, 8'h20);
    dump(8'h05, "R11 R10 move nonstatic");
    fm(3'd1, 8'h00, 4'hF, 8'h62);
    dump(8'h05, "R11 move all");
    dump(8'h35, "R11 move all other db");
    fm(3'd5, 8'h35, 4'hF, 8'hF6);
    dump(8'h35, "R12 remove");
    dump(8'h05, "R12 other db kept");
    fm(3'd6, 8'h05, 4'h0, 8'h00);
    dump(8'h05, "R9 R10 flush nonstatic one db");
    fm(3'd1, 8'h00, 4'h0, 8'h00);
    dump(8'h05, "R9 flush all");
    finish_run();
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog R1 actual running expected finished");
    finish_run();
  end
endmodule